// File: doc/BRIEF.md
# Byte-Lane Bridge to a Two-Beat Word Memory Port

This block joins a byte-wide processor bus to the port of a DRAM controller that moves 32-bit words. Each word crosses that port as two 16-bit beats on back-to-back transfers. The processor sees a flat byte address. The bridge splits that address into two parts: a word address for the controller, and a lane number that selects one of the four bytes in the word.

A processor read fetches the containing word and returns the addressed byte. A processor write first reads the containing word. It then replaces only the addressed byte and writes the whole word back, so the other three bytes keep their values.

The word address sent to the controller always has its lowest bit cleared. Every burst therefore starts on an even address, and the lower half of the word always arrives first. While a transfer runs, the bridge holds the processor with a wait output.

Top module: `bytelane_bridge`

## Requirements
- R1: After reset, `cpu_wait` is 0, `mem_req` is 0 and `cpu_rdata` is 0.
- R2: On every request, `mem_addr` equals `{cpu_addr[15:2], 1'b0}`. Its bit 0 is always 0.
- R3: Byte lane n of a word occupies bits 8n+7:8n. The first beat of a burst carries word bits 15:0 and the second beat carries bits 31:16, for both reads (`mem_rvalid`) and writes (`mem_wtake`).
- R4: A read returns on `cpu_rdata` the byte whose lane is given by `cpu_addr[1:0]`. The value is valid from the cycle in which `cpu_wait` falls.
- R5: A write issues a read request and then a write request to the same word. The written word equals the read word with only lane `cpu_addr[1:0]` replaced by `cpu_wdata`.
- R6: `cpu_wait` rises on the clock edge that accepts the strobe and falls on the edge that samples the final `mem_done` pulse. With a controller that answers a request with beats on the next two cycles and `mem_done` on the cycle after them, this gives 4 wait cycles for a read and 8 for a write.
- R7: A strobe that arrives while `cpu_wait` is 1 is ignored. It produces no request, changes no memory and leaves `cpu_rdata` as it was.
- R8: `mem_req` is a single-cycle pulse. A read produces exactly one request and a write produces exactly two.
- R9: `cpu_rdata` changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte |
| cpu_wait | output | 1 | Hold the processor while high |
| mem_req | output | 1 | One-cycle request pulse to the controller |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Half-word address, bit 0 forced to 0 |
| mem_wbeat | output | 16 | Current write beat |
| mem_wtake | input | 1 | Controller takes the current write beat |
| mem_rbeat | input | 16 | Read beat from the controller |
| mem_rvalid | input | 1 | Read beat valid |
| mem_done | input | 1 | Controller finished the request |

## Verification
A beat counter left in the wrong state, or a lane decode that is wrong, does not show up as a control fault. It shows up as a byte taken from the wrong lane, or as two halves of the written word that are swapped. Either one is visible on `cpu_rdata`, or in the memory model once `cpu_wait` falls, within 4 to 8 cycles of the strobe. A sequencer that loses its place shows up instead as a wrong number of wait cycles or a wrong number of requests. A strobe that leaks through while the bridge is busy shows up as an extra request and a changed word.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_COLLECT,
    S_WR_REQ,
    S_WR_PUSH
  } bl_state_e;

endpackage

// File: rtl/bl_seq.sv
module bl_seq
  import bl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_sel,
  input  logic      cpu_we,
  input  logic      mem_done,
  output logic      busy,
  output logic      mem_req,
  output logic      mem_we,
  output logic      ev_accept,
  output logic      ev_merge,
  output logic      ev_rd_finish,
  output logic      ev_wr_finish
);

  bl_state_e state_q, state_d;
  logic      we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:       if (cpu_sel) state_d = S_RD_REQ;
      S_RD_REQ:     state_d = S_RD_COLLECT;
      S_RD_COLLECT: if (mem_done) state_d = we_q ? S_WR_REQ : S_IDLE;
      S_WR_REQ:     state_d = S_WR_PUSH;
      S_WR_PUSH:    if (mem_done) state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) we_q <= cpu_we;
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign mem_req      = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign mem_we       = (state_q == S_WR_REQ) || (state_q == S_WR_PUSH);
  assign ev_accept    = (state_q == S_IDLE) && cpu_sel;
  assign ev_merge     = (state_q == S_RD_COLLECT) && mem_done && we_q;
  assign ev_rd_finish = (state_q == S_RD_COLLECT) && mem_done && !we_q;
  assign ev_wr_finish = (state_q == S_WR_PUSH) && mem_done;

endmodule

// File: rtl/bl_beats.sv
module bl_beats #(
  parameter int BEAT_W = 16,
  parameter int BEATS  = 2,
  localparam int WORD_W    = BEAT_W * BEATS,
  localparam int BEAT_BITS = $clog2(BEATS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 rvalid,
  input  logic [BEAT_W-1:0]    rbeat,
  input  logic                 wtake,
  input  logic [WORD_W-1:0]    wr_word,
  output logic [WORD_W-1:0]    rd_word,
  output logic [BEAT_W-1:0]    wbeat,
  output logic [BEAT_BITS-1:0] beat_idx
);

  // beat position within the burst; restarts on every request
  always_ff @(posedge clk) begin
    if (!rst_n || clear) beat_idx <= '0;
    else if (rvalid || wtake) beat_idx <= beat_idx + 1'b1;
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    logic [BEAT_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= '0;
      else if (rvalid && (beat_idx == BEAT_BITS'(g))) hold_q <= rbeat;
    end
    assign rd_word[g*BEAT_W +: BEAT_W] = hold_q;
  end

  assign wbeat = wr_word[beat_idx*BEAT_W +: BEAT_W];

endmodule

// File: rtl/bl_lanes.sv
module bl_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W    = LANE_W * LANES,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [WORD_W-1:0]    word,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [LANE_W-1:0]    new_byte,
  output logic [LANE_W-1:0]    picked,
  output logic [WORD_W-1:0]    merged
);

  logic [LANE_W-1:0] slice [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign slice[g] = word[g*LANE_W +: LANE_W];
    assign merged[g*LANE_W +: LANE_W] =
      (lane == LANE_BITS'(g)) ? new_byte : slice[g];
  end

  assign picked = slice[lane];

endmodule

// File: rtl/bytelane_bridge.sv
module bytelane_bridge #(
  parameter int CPU_AW = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int BEATS  = 2,
  localparam int WORD_W    = LANE_W * LANES,
  localparam int BEAT_W    = WORD_W / BEATS,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int BEAT_BITS = $clog2(BEATS),
  localparam int MAW       = CPU_AW - LANE_BITS + BEAT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [LANE_W-1:0] cpu_wdata,
  output logic [LANE_W-1:0] cpu_rdata,
  output logic              cpu_wait,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [BEAT_W-1:0] mem_wbeat,
  input  logic              mem_wtake,
  input  logic [BEAT_W-1:0] mem_rbeat,
  input  logic              mem_rvalid,
  input  logic              mem_done
);

  // word index with the beat-select bits cleared, so bursts start on the low half
  function automatic logic [MAW-1:0] burst_addr(input logic [CPU_AW-1:0] a);
    return {a[CPU_AW-1:LANE_BITS], {BEAT_BITS{1'b0}}};
  endfunction

  logic                 busy;
  logic                 ev_accept, ev_merge, ev_rd_finish, ev_wr_finish;
  logic [CPU_AW-1:0]    addr_q;
  logic [LANE_W-1:0]    wdata_q;
  logic [LANE_W-1:0]    rdata_q;
  logic [WORD_W-1:0]    wr_word_q;
  logic [WORD_W-1:0]    rd_word;
  logic [WORD_W-1:0]    merged;
  logic [LANE_W-1:0]    picked;
  logic [BEAT_BITS-1:0] beat_idx;

  bl_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_we       (cpu_we),
    .mem_done     (mem_done),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .ev_accept    (ev_accept),
    .ev_merge     (ev_merge),
    .ev_rd_finish (ev_rd_finish),
    .ev_wr_finish (ev_wr_finish)
  );

  bl_beats #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mem_req),
    .rvalid   (mem_rvalid),
    .rbeat    (mem_rbeat),
    .wtake    (mem_wtake),
    .wr_word  (wr_word_q),
    .rd_word  (rd_word),
    .wbeat    (mem_wbeat),
    .beat_idx (beat_idx)
  );

  bl_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .word     (rd_word),
    .lane     (addr_q[LANE_BITS-1:0]),
    .new_byte (wdata_q),
    .picked   (picked),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      wr_word_q <= '0;
    end else begin
      if (ev_accept) begin
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      if (ev_merge)     wr_word_q <= merged;
      if (ev_rd_finish) rdata_q   <= picked;
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_wait  = busy;
  assign mem_addr  = burst_addr(addr_q);

endmodule

// File: rtl/bytelane_bridge_chk.sv
module bytelane_bridge_chk #(
  parameter int MAW       = 15,
  parameter int BEAT_BITS = 1,
  parameter int LANE_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_sel,
  input logic              cpu_wait,
  input logic [LANE_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MAW-1:0]    mem_addr,
  input logic              mem_done,
  input logic              ev_accept,
  input logic              ev_merge,
  input logic              ev_rd_finish,
  input logic              ev_wr_finish
);

  // R2
  even_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[BEAT_BITS-1:0] == '0));

  // R6
  wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> cpu_wait);

  // R6
  wait_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_wait) |-> $past(mem_done));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_done));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && !mem_done) |=> cpu_wait);

  // R8
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_accept, ev_merge, ev_rd_finish, ev_wr_finish}));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd_finish |=> $stable(cpu_rdata));

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wait) |-> !ev_accept);

endmodule

bind bytelane_bridge bytelane_bridge_chk #(
  .MAW(MAW), .BEAT_BITS(BEAT_BITS), .LANE_W(LANE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_sel      (cpu_sel),
  .cpu_wait     (cpu_wait),
  .cpu_rdata    (cpu_rdata),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_done     (mem_done),
  .ev_accept    (ev_accept),
  .ev_merge     (ev_merge),
  .ev_rd_finish (ev_rd_finish),
  .ev_wr_finish (ev_wr_finish)
);

// File: tb/bytelane_bridge_tb.sv
module bytelane_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_sel, cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_wait, mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wbeat, mem_rbeat;
  logic        mem_wtake, mem_rvalid, mem_done;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bytelane_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_wait(cpu_wait), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wbeat(mem_wbeat), .mem_wtake(mem_wtake),
    .mem_rbeat(mem_rbeat), .mem_rvalid(mem_rvalid), .mem_done(mem_done)
  );

  // word memory model with a two-beat handshake, driven on the falling edge
  logic [31:0] mem [0:255];
  int          m_cnt = 0;
  logic        m_we;
  logic [7:0]  m_idx;
  logic [15:0] m_lo;
  int          req_cnt = 0;
  logic [14:0] last_addr;

  always @(negedge clk) begin
    mem_rvalid = 1'b0; mem_wtake = 1'b0; mem_done = 1'b0; mem_rbeat = 16'h0;
    if (!rst_n) m_cnt = 0;
    else if (m_cnt == 0) begin
      if (mem_req) begin
        m_cnt = 1; m_we = mem_we; m_idx = mem_addr[8:1];
        req_cnt++; last_addr = mem_addr;
      end
    end else begin
      case (m_cnt)
        1: if (m_we) begin mem_wtake = 1'b1; m_lo = mem_wbeat; end
           else begin mem_rvalid = 1'b1; mem_rbeat = mem[m_idx][15:0]; end
        2: if (m_we) begin mem_wtake = 1'b1; mem[m_idx] = {mem_wbeat, m_lo}; end
           else begin mem_rvalid = 1'b1; mem_rbeat = mem[m_idx][31:16]; end
        default: mem_done = 1'b1;
      endcase
      m_cnt = (m_cnt == 3) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d, output int waitc);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0;
    waitc = 0;
    while (cpu_wait && waitc < 100) begin waitc++; @(negedge clk); end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    chk(cpu_wait == 0, "R1 wait", 32'(cpu_wait), 0);
    chk(mem_req == 0, "R1 req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdata == 0, "R1 rdata", 32'(cpu_rdata), 0);
  endtask

  task automatic t_read_lanes;
    int w; int r0;
    mem[5] = 32'hA1B2C3D4;
    for (int l = 0; l < 4; l++) begin
      r0 = req_cnt;
      access(0, {14'd5, 2'(l)}, 8'h00, w);
      chk(cpu_rdata == mem[5][8*l +: 8], "R4 R3 lane byte", 32'(cpu_rdata), 32'(mem[5][8*l +: 8]));
      chk(last_addr == 15'd10, "R2 word addr", 32'(last_addr), 32'd10);
      chk(req_cnt - r0 == 1, "R8 read req count", 32'(req_cnt - r0), 1);
      chk(w == 4, "R6 read wait", 32'(w), 4);
    end
  endtask

  task automatic t_write;
    int w; int r0; logic [31:0] e;
    logic [7:0] rd_before;
    mem[3] = 32'h0BADF00D;
    access(0, {14'd3, 2'd1}, 8'h00, w);
    rd_before = cpu_rdata;
    mem[9] = 32'h11223344;
    for (int l = 0; l < 4; l++) begin
      r0 = req_cnt;
      e = mem[9];
      e[8*l +: 8] = 8'hE0 + 8'(l);
      access(1, {14'd9, 2'(l)}, 8'hE0 + 8'(l), w);
      chk(mem[9] == e, "R5 R3 merged word", mem[9], e);
      chk(req_cnt - r0 == 2, "R8 write req count", 32'(req_cnt - r0), 2);
      chk(w == 8, "R6 write wait", 32'(w), 8);
      chk(cpu_rdata == rd_before, "R9 rdata kept", 32'(cpu_rdata), 32'(rd_before));
    end
    access(0, {14'd9, 2'd2}, 8'h00, w);
    chk(cpu_rdata == 8'hE2, "R4 read back", 32'(cpu_rdata), 32'hE2);
  endtask

  task automatic t_high_addr;
    int w;
    mem[255] = 32'h5A6B7C8D;
    access(0, 16'hFFFF, 8'h00, w);
    chk(last_addr == 15'h7FFE, "R2 even top addr", 32'(last_addr), 32'h7FFE);
    chk(cpu_rdata == 8'h5A, "R4 top lane", 32'(cpu_rdata), 32'h5A);
    access(1, 16'hFFFE, 8'h99, w);
    chk(mem[255] == 32'h5A997C8D, "R5 top write", mem[255], 32'h5A997C8D);
  endtask

  task automatic t_ignore;
    int r0; int n;
    mem[12] = 32'hCAFEBABE;
    r0 = req_cnt;
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = {14'd5, 2'd0};
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = {14'd12, 2'd3}; cpu_wdata = 8'h77;
    @(negedge clk);
    cpu_sel = 1'b0;
    n = 0;
    while (cpu_wait && n < 100) begin n++; @(negedge clk); end
    repeat (10) @(negedge clk);
    chk(req_cnt - r0 == 1, "R7 no extra req", 32'(req_cnt - r0), 1);
    chk(mem[12] == 32'hCAFEBABE, "R7 memory untouched", mem[12], 32'hCAFEBABE);
    chk(cpu_rdata == 8'hD4, "R7 rdata from first", 32'(cpu_rdata), 32'hD4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    t_reset();
    t_read_lanes();
    t_write();
    t_high_addr();
    t_ignore();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule